// File: doc/BRIEF.md
# Continuous Scan Conversion Sequencer

This block is the digital controller in front of a multi-channel successive-approximation converter, run in repeating scan mode. Software writes one control word holding a run bit, an interrupt-enable bit, a sweep-complete flag, a divider select, a group select and a span field. While the run bit is 1 the sequencer walks through the selected channels in ascending order. For each channel it selects the input, holds a sampling window open and then pulses a start request to the converter core. When the core reports done, the sequencer stores the result word in that channel's own result register. Then it moves to the next channel.

The first conversion after the run bit goes from 0 to 1 waits for the next edge of the divided conversion clock. After that it gets a long sampling window. Every later conversion in the scan gets a shorter window, which starts at the done pulse of the conversion before it. Hardware never clears the run bit, so the group is swept again and again. Each completed sweep sets the flag, which raises an interrupt when enabled. Clearing the run bit parks the sequencer in a wait state. The next start begins again at the group's first channel.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control word reads 0, `irq`, `sample_o` and `conv_start` are low, and every result register reads 0.
- R2: The control word has these fields: bit 0 run, bit 1 interrupt enable, bit 2 sweep-complete flag, bits 4:3 divider select, bit 5 group select, bits 7:6 span. A write takes effect at the clock edge that samples `ctl_we`, and `ctl_rdata` returns the current fields in the same positions.
- R3: After a write that takes run from 0 to 1 (edge W), `conv_start` first rises at edge W+k, with FIRST+1 <= k <= FIRST+P. P is the divider period and FIRST is 3*P system cycles.
- R4: When a done pulse is sampled at edge D during a scan, the next `conv_start` rises at edge D+NEXT, where NEXT is 2*P system cycles.
- R5: A group with select G and span S covers channels G*4+0 up to G*4+S, converted in ascending order and then wrapping back to G*4+0. `ch_sel` gives the channel number.
- R6: A done pulse sampled while the sequencer waits for a result writes `conv_result` into the register of the channel being converted. The register reads back on `rd_data` when `rd_idx` names it.
- R7: The flag is set when the done pulse of the last channel of the group is taken. It is cleared only by a control write with bit 2 at 0. A write with bit 2 at 1 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R8: `irq` is 1 exactly when the flag and the interrupt-enable bit are both 1.
- R9: Hardware never clears the run bit. After the last channel the scan carries on with the first channel of the group.
- R10: From the second cycle after a write that clears run, `sample_o` and `conv_start` stay low. A done pulse in the wait state changes no result register.
- R11: A later 0-to-1 write of run restarts at the group's first channel with the first-conversion timing of R3.
- R12: Divider select C gives a divider period P of 2^(C+1) system cycles. P scales both sampling windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word readback |
| rd_idx | input | 3 | Result register index for readback |
| rd_data | output | 10 | Selected result register |
| irq | output | 1 | Sweep-complete interrupt request |
| ch_sel | output | 3 | Input channel select to the analog mux |
| sample_o | output | 1 | High while the sampling window is open |
| conv_start | output | 1 | One-cycle start request to the converter core |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | 10 | Conversion result, valid with `conv_done` |

## Verification
The assertions assume that the core sends at most one done pulse per start request, and only after it has seen that request. They also assume that the group select, span and divider select change only in a write that also starts the scan from the wait state. The stimulus honours both. The core model answers each observed start after a latency drawn at random, and it drops any pending answer once run is cleared. While a scan is running, the bench rewrites only the run, interrupt-enable and flag bits. Stray done pulses are injected only while the sequencer is stopped.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int NUM_CH      = 8;
  localparam int CH_PER_GRP  = 4;
  localparam int RES_W       = 10;
  localparam int CKS_W       = 2;
  localparam int FIRST_TICKS = 3;
  localparam int NEXT_TICKS  = 2;

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int OFF_W = $clog2(CH_PER_GRP);
  localparam int GRP_W = CH_W - OFF_W;
  localparam int DIV_W = (1 << CKS_W) + 1;
  localparam int WIN_W = DIV_W + 3;

  // control word layout
  localparam int B_RUN  = 0;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 2;
  localparam int B_CKS  = 3;
  localparam int B_GRP  = B_CKS + CKS_W;
  localparam int B_SPAN = B_GRP + GRP_W;
  localparam int CTL_W  = B_SPAN + OFF_W;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SAMPLE = 2'd1,
    S_CONV   = 2'd2
  } scan_state_e;

  // divided conversion clock period in system cycles
  function automatic logic [DIV_W-1:0] div_period(input logic [CKS_W-1:0] cks);
    return DIV_W'(2) << cks;
  endfunction

  // sampling window length in system cycles
  function automatic logic [WIN_W-1:0] win_cycles(input logic [CKS_W-1:0] cks,
                                                  input logic first);
    logic [WIN_W-1:0] per;
    per = WIN_W'(div_period(cks));
    return first ? per * WIN_W'(FIRST_TICKS) : per * WIN_W'(NEXT_TICKS);
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  always_comb last = div_period(cks) - DIV_W'(1);

  assign tick = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end

  // period is at least two cycles, so ticks never touch
  p_tick_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[i] <= '0;
      else if (wr_en && (wr_idx == AW'(i)))  slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CKS_W-1:0] cks,
  input  logic [GRP_W-1:0] grp,
  input  logic [OFF_W-1:0] span,
  input  logic             conv_done,
  output logic [CH_W-1:0]  ch_sel,
  output logic             sample_o,
  output logic             conv_start,
  output logic             store_en,
  output logic             wrap_evt
);

  scan_state_e      st;
  logic [OFF_W-1:0] off;
  logic [WIN_W-1:0] cnt;
  logic             start_q;
  logic             last_ch;

  assign last_ch    = (off == span);
  assign ch_sel     = {grp, off};
  assign sample_o   = (st == S_SAMPLE);
  assign conv_start = start_q;
  assign store_en   = (st == S_CONV) && conv_done;
  assign wrap_evt   = store_en && last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      off     <= '0;
      cnt     <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!run) begin
        st  <= S_IDLE;
        off <= '0;
      end else begin
        unique case (st)
          S_IDLE: if (tick) begin
            st  <= S_SAMPLE;
            off <= '0;
            cnt <= win_cycles(cks, 1'b1) - WIN_W'(1);
          end
          S_SAMPLE: begin
            if (cnt == '0) begin
              st      <= S_CONV;
              start_q <= 1'b1;
            end else begin
              cnt <= cnt - WIN_W'(1);
            end
          end
          S_CONV: if (conv_done) begin
            st  <= S_SAMPLE;
            off <= last_ch ? '0 : off + OFF_W'(1);
            cnt <= win_cycles(cks, 1'b0) - WIN_W'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && conv_start));

  p_wait_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_o && !conv_start));

  p_in_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (ch_sel[OFF_W-1:0] <= span));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [RES_W-1:0] rd_data,
  output logic             irq,
  output logic [CH_W-1:0]  ch_sel,
  output logic             sample_o,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);

  logic             run_q;
  logic             ie_q;
  logic             flag_q;
  logic [CKS_W-1:0] cks_q;
  logic [GRP_W-1:0] grp_q;
  logic [OFF_W-1:0] span_q;

  logic tick;
  logic store_en;
  logic wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      cks_q  <= '0;
      grp_q  <= '0;
      span_q <= '0;
    end else if (ctl_we) begin
      run_q  <= ctl_wdata[B_RUN];
      ie_q   <= ctl_wdata[B_IE];
      cks_q  <= ctl_wdata[B_CKS +: CKS_W];
      grp_q  <= ctl_wdata[B_GRP +: GRP_W];
      span_q <= ctl_wdata[B_SPAN +: OFF_W];
    end
  end

  // sweep-complete flag: set wins over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              flag_q <= 1'b0;
    else if (wrap_evt)                       flag_q <= 1'b1;
    else if (ctl_we && !ctl_wdata[B_FLAG])   flag_q <= 1'b0;
  end

  assign ctl_rdata = {span_q, grp_q, cks_q, flag_q, ie_q, run_q};
  assign irq       = flag_q && ie_q;

  adc_clk_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .cks   (cks_q),
    .tick  (tick)
  );

  adc_scan_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .tick       (tick),
    .cks        (cks_q),
    .grp        (grp_q),
    .span       (span_q),
    .conv_done  (conv_done),
    .ch_sel     (ch_sel),
    .sample_o   (sample_o),
    .conv_start (conv_start),
    .store_en   (store_en),
    .wrap_evt   (wrap_evt)
  );

  adc_result_bank #(.DEPTH(NUM_CH), .DW(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_en),
    .wr_idx  (ch_sel),
    .wr_data (conv_result),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap_evt));

  p_scan_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> run_q);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap_evt) || $past(ctl_we)));

endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  import adc_scan_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_we = 1'b0;
  logic [CTL_W-1:0] ctl_wdata = '0;
  logic [CTL_W-1:0] ctl_rdata;
  logic [CH_W-1:0]  rd_idx = '0;
  logic [RES_W-1:0] rd_data;
  logic             irq;
  logic [CH_W-1:0]  ch_sel;
  logic             sample_o;
  logic             conv_start;
  logic             conv_done = 1'b0;
  logic [RES_W-1:0] conv_result = '0;

  adc_scan_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  // bench configuration used to build writes
  logic [CKS_W-1:0] cfg_cks = '0;
  logic [GRP_W-1:0] cfg_grp = '0;
  logic [OFF_W-1:0] cfg_span = '0;
  logic             cfg_ie = 1'b0;
  int               core_lat = 2;

  // expected state, updated at clock edges from driven inputs
  logic             exp_run = 1'b0, exp_run_d = 1'b0, exp_ie = 1'b0, exp_flag = 1'b0;
  logic [CKS_W-1:0] exp_cks = '0;
  logic [GRP_W-1:0] exp_grp = '0;
  logic [OFF_W-1:0] exp_span = '0;
  logic [OFF_W-1:0] exp_off = '0;
  logic [RES_W-1:0] exp_res [NUM_CH];
  int  cyc = 0, start_cyc = 0, done_cyc = 0, sweeps = 0;
  bit  first_pend = 1'b0;

  // core model state
  bit               busy = 1'b0, inject_req = 1'b0, cur_last = 1'b0;
  int               ccnt = 0;
  logic [CH_W-1:0]  cur_ch = '0;
  logic [RES_W-1:0] cur_val = '0, inj_val = '0;

  function automatic int per_of(input int c);
    return 1 << (c + 1);
  endfunction
  function automatic int first_len(input int c);
    return 3 * per_of(c);
  endfunction
  function automatic int next_len(input int c);
    return 2 * per_of(c);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic put_ctl(input logic run, input logic keep_flag);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = {cfg_span, cfg_grp, cfg_cks, keep_flag, cfg_ie, run};
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  task automatic read_chk(input int idx, input string req);
    rd_idx = CH_W'(idx);
    #1;
    check(rd_data == exp_res[idx], req, rd_data, exp_res[idx]);
  endtask

  task automatic wait_sweeps(input int n);
    int target;
    target = sweeps + n;
    wait (sweeps >= target);
    @(negedge clk);
  endtask

  // converter core model
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (inject_req) begin
      conv_done   = 1'b1;
      conv_result = inj_val;
      inject_req  = 1'b0;
    end else if (!exp_run) begin
      busy = 1'b0;
    end else if (conv_start) begin
      busy     = 1'b1;
      ccnt     = core_lat;
      cur_ch   = ch_sel;
      cur_last = (ch_sel[OFF_W-1:0] == exp_span);
      cur_val  = RES_W'($urandom);
    end else if (busy) begin
      if (ccnt == 0) begin
        conv_done   = 1'b1;
        conv_result = cur_val;
        busy        = 1'b0;
      end else begin
        ccnt--;
      end
    end
  end

  // expected-state update at each edge (inputs are stable here)
  always @(posedge clk) begin
    bit set_f;
    cyc++;
    if (rst_n) begin
      set_f = 1'b0;
      if (conv_done && exp_run) begin
        exp_res[cur_ch] = cur_val;
        done_cyc = cyc;
        if (cur_last) begin
          set_f = 1'b1;
          sweeps++;
        end
      end
      exp_run_d = exp_run;
      if (ctl_we) begin
        if (ctl_wdata[B_RUN] && !exp_run) begin
          exp_off    = '0;
          first_pend = 1'b1;
          start_cyc  = cyc;
        end
        exp_run  = ctl_wdata[B_RUN];
        exp_ie   = ctl_wdata[B_IE];
        exp_cks  = ctl_wdata[B_CKS +: CKS_W];
        exp_grp  = ctl_wdata[B_GRP +: GRP_W];
        exp_span = ctl_wdata[B_SPAN +: OFF_W];
        if (!ctl_wdata[B_FLAG]) exp_flag = 1'b0;
      end
      if (set_f) exp_flag = 1'b1;
    end
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      check(ctl_rdata[B_FLAG] == exp_flag, "R7 sweep flag", ctl_rdata[B_FLAG], exp_flag);
      check(ctl_rdata[B_RUN] == exp_run, "R9 run bit held", ctl_rdata[B_RUN], exp_run);
      check({ctl_rdata[CTL_W-1:B_CKS], ctl_rdata[B_IE]} == {exp_span, exp_grp, exp_cks, exp_ie},
            "R2 control readback", ctl_rdata, {exp_span, exp_grp, exp_cks, exp_flag, exp_ie, exp_run});
      check(irq == (exp_flag && exp_ie), "R8 irq", irq, exp_flag && exp_ie);
      if (!exp_run && !exp_run_d)
        check(!sample_o && !conv_start, "R10 wait state quiet", {sample_o, conv_start}, 0);
      if (conv_start && exp_run) begin
        check(ch_sel == {exp_grp, exp_off}, "R5 channel order", ch_sel, {exp_grp, exp_off});
        if (first_pend) begin
          check((cyc - start_cyc >= first_len(exp_cks) + 1) &&
                (cyc - start_cyc <= first_len(exp_cks) + per_of(exp_cks)),
                $sformatf("R3 R11 R12 first start delay (lo %0d hi %0d)",
                          first_len(exp_cks) + 1, first_len(exp_cks) + per_of(exp_cks)),
                cyc - start_cyc, first_len(exp_cks) + 1);
          first_pend = 1'b0;
        end else begin
          check(cyc - done_cyc == next_len(exp_cks), "R4 R12 later conversion spacing",
                cyc - done_cyc, next_len(exp_cks));
        end
        exp_off = (exp_off == exp_span) ? '0 : exp_off + OFF_W'(1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    logic [RES_W-1:0] snap [NUM_CH];
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_CH; i++) exp_res[i] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(ctl_rdata == '0, "R1 control after reset", ctl_rdata, 0);
    check(!irq && !sample_o && !conv_start, "R1 outputs after reset",
          {irq, sample_o, conv_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) read_chk(i, "R1 result after reset");
    mon_on = 1'b1;

    // directed: fastest divider, upper group, full span, irq on
    cfg_cks = 2'd0; cfg_grp = 1'b1; cfg_span = 2'd3; cfg_ie = 1'b1; core_lat = 3;
    put_ctl(1'b1, 1'b1);
    wait_sweeps(2);
    for (int i = 0; i < CH_PER_GRP; i++) read_chk(4 + i, "R6 stored result");
    check(ctl_rdata[B_RUN] == 1'b1, "R9 run still set after sweeps", ctl_rdata[B_RUN], 1);
    check(irq == 1'b1, "R8 irq after sweep", irq, 1);

    // R7 write with flag bit 1 keeps it, bit 0 clears it
    put_ctl(1'b1, 1'b1);
    check(ctl_rdata[B_FLAG] == exp_flag, "R7 keep on write of 1", ctl_rdata[B_FLAG], exp_flag);
    put_ctl(1'b1, 1'b0);

    // R8 interrupt disabled: flag sets, irq stays low
    cfg_ie = 1'b0;
    put_ctl(1'b1, 1'b1);
    wait_sweeps(1);
    check(ctl_rdata[B_FLAG] == 1'b1 && irq == 1'b0, "R8 irq masked",
          {ctl_rdata[B_FLAG], irq}, 2);

    // R10 stop, then stray done pulse must be ignored
    put_ctl(1'b0, 1'b1);
    repeat (60) @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) snap[i] = exp_res[i];
    inj_val = 10'h2A5;
    inject_req = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) begin
      rd_idx = CH_W'(i);
      #1;
      check(rd_data == snap[i], "R10 done ignored while stopped", rd_data, snap[i]);
    end

    // R11 restart, slowest divider, two-channel lower group, instant core
    cfg_cks = 2'd3; cfg_grp = 1'b0; cfg_span = 2'd1; cfg_ie = 1'b1; core_lat = 0;
    put_ctl(1'b1, 1'b0);
    wait_sweeps(2);
    put_ctl(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) read_chk(i, "R6 stored result lower group");

    // single-channel group
    cfg_cks = 2'd1; cfg_grp = 1'b1; cfg_span = 2'd0; core_lat = 5;
    put_ctl(1'b1, 1'b0);
    wait_sweeps(3);
    put_ctl(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    read_chk(4, "R6 single-channel group");

    // random: configurations, latencies, mid-scan stops and restarts
    for (int it = 0; it < 14; it++) begin
      cfg_cks  = CKS_W'($urandom_range(3, 0));
      cfg_grp  = GRP_W'($urandom_range(1, 0));
      cfg_span = OFF_W'($urandom_range(3, 0));
      cfg_ie   = 1'($urandom_range(1, 0));
      core_lat = $urandom_range(20, 0);
      put_ctl(1'b1, 1'($urandom_range(1, 0)));
      repeat ($urandom_range(600, 20)) @(negedge clk);
      if ($urandom_range(1, 0) == 1) put_ctl(1'b1, 1'b0);
      repeat ($urandom_range(200, 0)) @(negedge clk);
      put_ctl(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      for (int i = 0; i < NUM_CH; i++) read_chk(i, "R6 results after random scan");
    end

    finish_run();
  end

endmodule